// File: doc/BRIEF.md
# Regular-Group Scan Sequencer

This block drives a multichannel analog-to-digital converter through a programmable scan list. The list holds up to sixteen slots. Each slot names any channel number. A run starts either on a software start pulse or on a chosen edge of an external trigger line. The block then walks the slots in ascending order. For each slot it presents the channel to an abstract converter along with a one-cycle start pulse, and it waits for the converter's done pulse before it moves on.

Three scan behaviours are available. A single run makes one pass over the list for each trigger. A continuous run keeps repeating the list with no further triggers until the block is disabled. A burst run converts only the next group of N slots per trigger, and it wraps to the first slot after the last one. A strobe marks the end of every conversion, and a second strobe marks the end of each full pass.

Configuration writes go through a small address/data port. They are accepted only while the sequencer is idle. A refused write sets a sticky error flag.

Top module: `adc_scan_sequencer`

## Requirements
- R1: After reset the block is idle with `busy`, `conv_start`, `eoc`, `eos` and `cfg_err` all 0. The list length is one slot, every slot holds channel 0, the trigger is software start, and the scan mode is single.
- R2: Writing address 16 with value L sets the list length to L+1 slots, using bits [3:0]; L=0 converts one channel only. Writing address k (0..15) stores channel bits [4:0] in slot k. Slots are converted from slot 0 upward, and `conv_ch` shows the slot's stored channel.
- R3: With software trigger selected (address 18, bit 0 = 0), a `sw_start` pulse while idle and enabled makes exactly one pass in single mode. `busy` then returns to 0.
- R4: With external trigger selected (address 18, bit 0 = 1), `sw_start` is ignored. Address 19 bits [1:0] pick the edge of `ext_trig` that starts a run: 1 selects rising, 2 selects falling, 3 selects both.
- R5: Writing address 18 with bit 0 = 1 sets the edge selection to rising, whatever it was before.
- R6: Continuous mode (address 17, bit 0 = 1) restarts from slot 0 after each pass with no new trigger. It stops only when `adc_en` is low, and `busy` is 0 one cycle after `adc_en` goes low.
- R7: Burst mode (address 17, bit 1 = 1, with N-1 in bits [4:2]) converts the next N slots per trigger, stopping early at the last slot. The trigger after the last slot starts again at slot 0.
- R8: Triggers, whether software or external, that arrive while a run or burst is still active are ignored.
- R9: A configuration write made while `busy` is 1 is dropped and sets `cfg_err`. A mode write that sets both continuous and burst is also dropped and sets `cfg_err`. `cfg_err` stays set until reset.
- R10: `eoc` pulses for one cycle in the cycle after each sampled `conv_done`. `eos` pulses together with the `eoc` of the last slot.
- R11: `conv_start` is a single-cycle pulse. The block then holds until `conv_done` before it issues the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_en | input | 1 | Sequencer enable; low aborts any run |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration address (0..15 slots, 16 length, 17 mode, 18 trigger source, 19 edge) |
| cfg_wdata | input | 8 | Configuration write data |
| sw_start | input | 1 | Software start pulse |
| ext_trig | input | 1 | External trigger level |
| conv_done | input | 1 | Converter finished the current channel |
| conv_start | output | 1 | Start request to the converter |
| conv_ch | output | 5 | Channel for the current request |
| eoc | output | 1 | End-of-conversion strobe |
| eos | output | 1 | End-of-pass strobe |
| busy | output | 1 | A run or burst is in progress |
| cfg_err | output | 1 | Sticky refused-write flag |

## Verification
Single passes are tested with random list lengths, random channel contents and random converter latency. These runs separate correct slot ordering and length decoding from off-by-one stepping. External trigger patterns toggle the line through every edge setting. They show whether each edge qualifies alone, and whether selecting the external source resets the edge choice. Directed cases cover the remaining modes: bursts across the wrap point, continuous repetition stopped by disable, extra triggers and writes during a long conversion, and a forbidden mode combination. These cases separate the burst counter, the lock and the error flag from the plain stepping path.

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer #(
  parameter int NUM_RANKS = 16,
  parameter int CH_W      = 5,
  parameter int DISC_MAX  = 8,
  parameter int AW        = $clog2(NUM_RANKS + 4)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adc_en,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [7:0]      cfg_wdata,
  input  logic            sw_start,
  input  logic            ext_trig,
  input  logic            conv_done,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_ch,
  output logic            eoc,
  output logic            eos,
  output logic            busy,
  output logic            cfg_err
);
  localparam int IW = $clog2(NUM_RANKS);
  localparam int DW = $clog2(DISC_MAX);
  localparam logic [AW-1:0] A_LEN  = AW'(NUM_RANKS);
  localparam logic [AW-1:0] A_MODE = AW'(NUM_RANKS + 1);
  localparam logic [AW-1:0] A_TRIG = AW'(NUM_RANKS + 2);
  localparam logic [AW-1:0] A_EDGE = AW'(NUM_RANKS + 3);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t             state;
  logic [CH_W-1:0] rank_ch [NUM_RANKS];
  logic [IW-1:0]   last_idx, idx;
  logic [DW-1:0]   disc_last, burst_cnt;
  logic            cont_md, disc_md, trig_ext, ext_q;
  logic [1:0]      edge_sel;

  wire ext_hit   = (edge_sel[0] & ext_trig & ~ext_q) | (edge_sel[1] & ~ext_trig & ext_q);
  wire start_ok  = adc_en && (state == S_IDLE) && (trig_ext ? ext_hit : sw_start);
  wire seq_last  = (idx == last_idx);
  wire burst_end = seq_last || (disc_md && burst_cnt == disc_last);
  wire cfg_ok    = cfg_we && (state == S_IDLE);
  wire mode_bad  = cfg_wdata[0] & cfg_wdata[1];

  assign busy       = (state != S_IDLE);
  assign conv_start = (state == S_REQ);
  assign conv_ch    = rank_ch[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_RANKS; i++) rank_ch[i] <= '0;
      last_idx  <= '0;
      cont_md   <= 1'b0;
      disc_md   <= 1'b0;
      disc_last <= '0;
      trig_ext  <= 1'b0;
      edge_sel  <= 2'b01;
      cfg_err   <= 1'b0;
    end else begin
      if (cfg_we && (busy || (cfg_addr == A_MODE && mode_bad))) cfg_err <= 1'b1;
      if (cfg_ok) begin
        if (cfg_addr < AW'(NUM_RANKS)) begin
          rank_ch[cfg_addr[IW-1:0]] <= cfg_wdata[CH_W-1:0];
        end else begin
          case (cfg_addr)
            A_LEN:  last_idx <= cfg_wdata[IW-1:0];
            A_MODE: if (!mode_bad) begin
                      cont_md   <= cfg_wdata[0];
                      disc_md   <= cfg_wdata[1];
                      disc_last <= cfg_wdata[2 +: DW];
                    end
            A_TRIG: begin
                      trig_ext <= cfg_wdata[0];
                      if (cfg_wdata[0]) edge_sel <= 2'b01;
                    end
            A_EDGE: edge_sel <= cfg_wdata[1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= '0;
      burst_cnt <= '0;
      eoc       <= 1'b0;
      eos       <= 1'b0;
      ext_q     <= 1'b0;
    end else begin
      ext_q <= ext_trig;
      eoc   <= 1'b0;
      eos   <= 1'b0;
      if (!adc_en) begin
        state     <= S_IDLE;
        idx       <= '0;
        burst_cnt <= '0;
      end else begin
        case (state)
          S_IDLE: begin
            if (cfg_ok) begin
              idx       <= '0;
              burst_cnt <= '0;
            end
            if (start_ok) state <= S_REQ;
          end
          S_REQ: state <= S_WAIT;
          S_WAIT: if (conv_done) begin
            eoc       <= 1'b1;
            eos       <= seq_last;
            idx       <= seq_last ? '0 : idx + 1'b1;
            burst_cnt <= burst_end ? '0 : burst_cnt + 1'b1;
            state     <= (!burst_end || cont_md) ? S_REQ : S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assert_start_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  assert_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);
  assert_eos_with_eoc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eos |-> eoc);
  assert_eoc_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> $past(conv_done));
  assert_lock_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && busy) |=> cfg_err);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  assert_disable_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_en |=> !busy);
endmodule

// File: tb/adc_scan_sequencer_tb.sv
`timescale 1ns/1ps
module adc_scan_sequencer_tb;
  localparam int A_LEN = 16, A_MODE = 17, A_TRIG = 18, A_EDGE = 19;

  logic clk = 0, rst_n = 0, adc_en = 1, cfg_we = 0, sw_start = 0, ext_trig = 0, conv_done = 0;
  logic [4:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic conv_start, eoc, eos, busy, cfg_err;
  logic [4:0] conv_ch;

  int total = 0, bad = 0, cyc = 0;
  int ch_log[$];
  int eoc_n = 0, eos_n = 0, pulse_viol = 0;
  int exp_rank[16];
  int lat_min = 1, lat_span = 4, resp_cnt = 0;
  bit prev_start = 0;

  always #2.5 clk = ~clk;

  adc_scan_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .adc_en(adc_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sw_start(sw_start), .ext_trig(ext_trig), .conv_done(conv_done),
    .conv_start(conv_start), .conv_ch(conv_ch), .eoc(eoc), .eos(eos), .busy(busy),
    .cfg_err(cfg_err));

  always @(negedge clk) begin
    conv_done = 0;
    if (resp_cnt > 0) begin
      resp_cnt--;
      if (resp_cnt == 0) conv_done = 1;
    end
    if (conv_start) resp_cnt = lat_min + int'($urandom % lat_span);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (conv_start) ch_log.push_back(int'(conv_ch));
      if (conv_start && prev_start) pulse_viol++;
      if (eoc) eoc_n++;
      if (eos) eos_n++;
    end
    prev_start = conv_start;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++; total++;
      $display("FAIL watchdog (all R): actual=%0d expected<%0d cycles", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(int a, int d);
    cfg_addr = 5'(a); cfg_wdata = 8'(d); cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_sw();
    sw_start = 1;
    @(negedge clk);
    sw_start = 0;
  endtask

  task automatic set_ext(bit v);
    ext_trig = v;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 3000) begin
      @(negedge clk);
      t++;
    end
    step(8);
  endtask

  task automatic clr();
    ch_log.delete(); eoc_n = 0; eos_n = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; step(3); rst_n = 1; step(2);
    for (int i = 0; i < 16; i++) exp_rank[i] = 0;
    clr();
  endtask

  function automatic int pass_ch(int pos, int len);
    return exp_rank[pos % len];
  endfunction

  initial begin
    void'($urandom(32'h5eed_0a1c));
    do_reset();

    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "conv_start after reset", int'(conv_start), 0);
    chk("R1", "eoc|eos after reset", int'(eoc | eos), 0);
    chk("R1", "cfg_err after reset", int'(cfg_err), 0);

    pulse_sw(); wait_idle();
    chk("R1", "default pass length", ch_log.size(), 1);
    if (ch_log.size() > 0) chk("R1", "default channel", ch_log[0], 0);
    chk("R3", "busy after single pass", int'(busy), 0);

    for (int it = 0; it < 8; it++) begin
      int n = 1 + int'($urandom % 16);
      if (it == 0) n = 16;
      if (it == 1) n = 1;
      for (int r = 0; r < n; r++) begin
        exp_rank[r] = int'($urandom % 32);
        cfg(r, exp_rank[r]);
      end
      cfg(A_LEN, n - 1);
      clr(); pulse_sw(); wait_idle();
      chk("R2", "conversions per pass", ch_log.size(), n);
      for (int r = 0; r < n && r < ch_log.size(); r++)
        chk("R2", $sformatf("slot %0d channel", r), ch_log[r], exp_rank[r]);
      chk("R10", "eoc count", eoc_n, n);
      chk("R10", "eos count", eos_n, 1);
      chk("R3", "idle after pass", int'(busy), 0);
    end

    exp_rank[0] = 6; exp_rank[1] = 21;
    cfg(0, 6); cfg(1, 21); cfg(A_LEN, 1);
    cfg(A_TRIG, 1); clr();
    pulse_sw(); wait_idle();
    chk("R4", "sw_start ignored under external", ch_log.size(), 0);
    set_ext(1); wait_idle();
    chk("R5", "default rising edge starts", ch_log.size(), 2);
    set_ext(0); wait_idle();
    chk("R5", "falling ignored by default", ch_log.size(), 2);
    cfg(A_EDGE, 2);
    set_ext(1); wait_idle();
    chk("R4", "rising ignored on falling select", ch_log.size(), 2);
    set_ext(0); wait_idle();
    chk("R4", "falling edge starts", ch_log.size(), 4);
    cfg(A_EDGE, 3);
    set_ext(1); wait_idle();
    chk("R4", "both: rising starts", ch_log.size(), 6);
    set_ext(0); wait_idle();
    chk("R4", "both: falling starts", ch_log.size(), 8);
    cfg(A_EDGE, 2); cfg(A_TRIG, 1);
    set_ext(1); wait_idle();
    chk("R5", "reselect restores rising", ch_log.size(), 10);
    set_ext(0); wait_idle();
    chk("R5", "falling ignored after reselect", ch_log.size(), 10);
    if (ch_log.size() > 1) chk("R4", "external pass channel", ch_log[1], 21);

    lat_min = 10; lat_span = 1;
    for (int r = 0; r < 4; r++) begin exp_rank[r] = 3 + r; cfg(r, 3 + r); end
    cfg(A_LEN, 3); clr();
    set_ext(1); step(3); set_ext(0); step(2); set_ext(1); step(2); set_ext(0);
    wait_idle();
    chk("R8", "external edges during run ignored", ch_log.size(), 4);
    cfg(A_TRIG, 0); clr();
    pulse_sw(); step(3); pulse_sw(); step(5); pulse_sw();
    wait_idle();
    chk("R8", "sw_start during run ignored", ch_log.size(), 4);
    chk("R8", "one eos for one trigger", eos_n, 1);

    clr(); pulse_sw(); step(2);
    cfg(0, 29);
    chk("R9", "cfg_err after busy write", int'(cfg_err), 1);
    wait_idle(); clr(); pulse_sw(); wait_idle();
    if (ch_log.size() > 0) chk("R9", "slot 0 kept after refused write", ch_log[0], 3);
    else chk("R9", "pass after refused write", 0, 4);
    step(20);
    chk("R9", "cfg_err sticky", int'(cfg_err), 1);
    lat_min = 1; lat_span = 4;

    do_reset();
    chk("R1", "cfg_err cleared by reset", int'(cfg_err), 0);
    cfg(A_MODE, 3);
    chk("R9", "cfg_err on continuous+burst", int'(cfg_err), 1);
    pulse_sw(); wait_idle();
    chk("R9", "mode unchanged: single pass", ch_log.size(), 1);
    chk("R9", "mode unchanged: idle", int'(busy), 0);

    for (int r = 0; r < 3; r++) begin exp_rank[r] = 10 + 5 * r; cfg(r, exp_rank[r]); end
    cfg(A_LEN, 2); cfg(A_MODE, 1); clr();
    pulse_sw();
    begin
      int t = 0;
      while (eos_n < 3 && t < 2000) begin @(negedge clk); t++; end
    end
    chk("R6", "still busy in continuous", int'(busy), 1);
    adc_en = 0; step(1);
    chk("R6", "idle after disable", int'(busy), 0);
    step(10); adc_en = 1; step(2);
    chk("R6", "repeated conversions", int'(ch_log.size() >= 9), 1);
    for (int i = 0; i < 9 && i < ch_log.size(); i++)
      chk("R6", $sformatf("continuous order %0d", i), ch_log[i], pass_ch(i, 3));

    exp_rank[0] = 7; exp_rank[1] = 3; exp_rank[2] = 12; exp_rank[3] = 1; exp_rank[4] = 30;
    for (int r = 0; r < 5; r++) cfg(r, exp_rank[r]);
    cfg(A_LEN, 4); cfg(A_MODE, 6); clr();
    pulse_sw(); wait_idle();
    chk("R7", "first burst size", ch_log.size(), 2);
    chk("R7", "no eos mid-sequence", eos_n, 0);
    pulse_sw(); wait_idle();
    chk("R7", "second burst size", ch_log.size(), 4);
    pulse_sw(); wait_idle();
    chk("R7", "short final burst", ch_log.size(), 5);
    chk("R10", "eos at last slot", eos_n, 1);
    pulse_sw(); wait_idle();
    chk("R7", "wrap burst size", ch_log.size(), 7);
    for (int i = 0; i < 7 && i < ch_log.size(); i++)
      chk("R7", $sformatf("burst order %0d", i), ch_log[i], pass_ch(i, 5));
    chk("R10", "eoc per conversion", eoc_n, 7);

    chk("R11", "start pulse never two cycles", pulse_viol, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule